// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

This block is one channel of a timer that measures how long passes between valid transitions on an input pin. Once started, it counts upward by one on every cycle where an external count-enable tick is high. When a transition of the selected polarity reaches it, it does three things in the same clock cycle. It copies the running count into a capture register, returns the counter to zero and raises a one-cycle interrupt. The captured value is therefore the number of ticks in the interval that just ended. A software capture strobe has the same effect as a pin transition.

The pin is synchronised by a flop chain. An optional glitch filter can then be placed in its path. The filter admits a new level only after the level has been seen for a set number of consecutive clocks. Each capture also rewrites an overflow flag, which reports whether the counter wrapped during the interval it just ended. A start strobe can optionally raise an interrupt of its own. A stop strobe freezes the counter, the capture register and the overflow flag.

Top module: `pulse_interval_timer`

## Requirements
- R1: A start strobe sets `running_o`, clears `count_o` to zero and clears any pending wrap. The counter then advances by one only on clock cycles where `tick_i` is 1 while running. A tick in the same cycle as a capture is discarded.
- R2: When `start_irq_en_i` is 1 in the cycle of the start strobe, `irq_o` is 1 for exactly the following cycle. When it is 0, start raises no interrupt.
- R3: The capture value equals the number of ticks since the previous start or capture, modulo 2^CNT_W.
- R4: Edge selection through `edge_sel_i` works as follows: 2'b00 selects falling transitions, 2'b01 rising, and 2'b10 or 2'b11 both. A selected transition while running captures `count_o` into `cap_data_o`, clears the counter and pulses `irq_o` for one cycle.
- R5: `sw_cap_i` while running has the same effect as a selected pin transition.
- R6: At every capture, `ovf_o` becomes 1 if the counter wrapped from all-ones to zero during the interval just ended, and 0 otherwise.
- R7: A stop strobe clears `running_o`. After that, `count_o`, `cap_data_o` and `ovf_o` hold their values, and neither pin transitions nor `sw_cap_i` cause a capture or an interrupt. Stop has priority over a start in the same cycle.
- R8: With the filter in use, a level must be sampled identically on FILT_LEN consecutive clocks after synchronisation before it is accepted, so a one-cycle pulse is rejected. With the filter bypassed, the synchronised pin is used directly.
- R9: `filt_en_i` is sampled at the start strobe. Changing it while running has no effect until the next start.
- R10: With SYNC_STAGES=2, a pin change that is applied just after a clock edge is captured at the third following edge when the filter is bypassed. With FILT_LEN=2 and the filter in use, it is captured at the fifth following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable pulse from the prescaler |
| pin_i | input | 1 | Asynchronous timer input pin |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| sw_cap_i | input | 1 | Software capture strobe |
| edge_sel_i | input | 2 | Transition select (00 fall, 01 rise, 1x both) |
| filt_en_i | input | 1 | Glitch filter enable, sampled at start |
| start_irq_en_i | input | 1 | Raise an interrupt on start |
| count_o | output | CNT_W | Live counter value |
| cap_data_o | output | CNT_W | Captured interval |
| ovf_o | output | 1 | Overflow of the last captured interval |
| running_o | output | 1 | Channel is counting |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the channel with CNT_W=8, while SYNC_STAGES=2 and FILT_LEN=2 keep their defaults. With an 8-bit counter, the wrap can be reached within a few hundred cycles, so every software-capture interval from 1 to 299 ticks is swept. That sweep covers both sides of the overflow boundary and the modulo capture values. The two-stage synchroniser and two-sample filter make the pin-to-capture latencies short enough to check cycle-exactly. A one-cycle glitch then separates the filtered path from the bypassed path.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam logic [1:0] SEL_FALL = 2'b00;
  localparam logic [1:0] SEL_RISE = 2'b01;

  // Whether a detected transition matches the selected polarity
  function automatic logic edge_match(input logic [1:0] sel,
                                      input logic rise, input logic fall);
    if (sel[1])             return rise | fall;
    else if (sel == SEL_RISE) return rise;
    else                    return fall;
  endfunction

  // True when the next tick wraps the counter to zero
  function automatic logic at_wrap(input logic [63:0] cnt, input int unsigned w);
    logic all_ones;
    all_ones = 1'b1;
    for (int i = 0; i < w; i++) all_ones &= cnt[i];
    return all_ones;
  endfunction

endpackage

// File: rtl/pit_input_cond.sv
module pit_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic filt_on_i,
  output logic level_o
);
  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;
  logic                   filt_lvl_q;
  logic                   synced;
  logic [FILT_LEN-1:0]    window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end
  assign synced = sync_q[SYNC_STAGES-1];

  assign window = {hist_q, synced};

  generate
    if (HIST_W == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= synced;
      end
    end else begin : g_histn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST_W-2:0], synced};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           filt_lvl_q <= 1'b0;
    else if (&window)     filt_lvl_q <= 1'b1;
    else if (~|window)    filt_lvl_q <= 1'b0;
  end

  assign level_o = filt_on_i ? filt_lvl_q : synced;
endmodule

// File: rtl/pit_edge_det.sv
module pit_edge_det
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  logic lvl_d;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= level_i;
  end

  assign rise  = level_i & ~lvl_d;
  assign fall  = ~level_i & lvl_d;
  assign hit_o = edge_match(sel_i, rise, fall);
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             cap_req_i,
  input  logic             start_irq_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             ovf_o,
  output logic             run_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cap_q;
  logic             run_q, ovf_q, wrap_pend_q, irq_q;
  logic             do_start, do_cap, do_tick;

  assign do_start = start_i & ~stop_i;
  assign do_cap   = run_q & cap_req_i & ~stop_i & ~start_i;
  assign do_tick  = run_q & tick_i & ~stop_i & ~start_i & ~cap_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      cap_q       <= '0;
      run_q       <= 1'b0;
      ovf_q       <= 1'b0;
      wrap_pend_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (do_start) begin
        run_q       <= 1'b1;
        cnt_q       <= '0;
        wrap_pend_q <= 1'b0;
        irq_q       <= start_irq_en_i;
      end else if (do_cap) begin
        cap_q       <= cnt_q;
        cnt_q       <= '0;
        ovf_q       <= wrap_pend_q;
        wrap_pend_q <= 1'b0;
        irq_q       <= 1'b1;
      end else if (do_tick) begin
        cnt_q <= cnt_q + 1'b1;
        if (at_wrap(64'(cnt_q), CNT_W)) wrap_pend_q <= 1'b1;
      end
    end
  end

  assign count_o = cnt_q;
  assign cap_o   = cap_q;
  assign ovf_o   = ovf_q;
  assign run_o   = run_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sw_cap_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             filt_en_i,
  input  logic             start_irq_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_data_o,
  output logic             ovf_o,
  output logic             running_o,
  output logic             irq_o
);
  logic filt_cfg_q;
  logic pin_level;
  logic edge_hit;
  logic cap_evt;

  // Filter choice is frozen for the whole run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  filt_cfg_q <= 1'b0;
    else if (start_i && !stop_i) filt_cfg_q <= filt_en_i;
  end

  pit_input_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .filt_on_i(filt_cfg_q), .level_o(pin_level)
  );

  pit_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(pin_level),
    .sel_i(edge_sel_i), .hit_o(edge_hit)
  );

  assign cap_evt = edge_hit | sw_cap_i;

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .start_i(start_i), .stop_i(stop_i), .cap_req_i(cap_evt),
    .start_irq_en_i(start_irq_en_i),
    .count_o(count_o), .cap_o(cap_data_o), .ovf_o(ovf_o),
    .run_o(running_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             start_irq_en_i,
  input logic             cap_evt,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cap_data_o,
  input logic             ovf_o,
  input logic             running_o,
  input logic             irq_o
);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (count_o == '0 && running_o));

  a_r2_start_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i && start_irq_en_i) |=> irq_o);

  a_r1_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && tick_i && !cap_evt && !start_i && !stop_i)
      |=> count_o == CNT_W'($past(count_o) + 1'b1));

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && cap_evt && !start_i && !stop_i)
      |=> (irq_o && count_o == '0 && cap_data_o == $past(count_o)));

  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !running_o);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !start_i)
      |=> ($stable(count_o) && $stable(cap_data_o) && $stable(ovf_o) && !irq_o));
endmodule

bind pulse_interval_timer pit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i),
  .stop_i(stop_i), .start_irq_en_i(start_irq_en_i), .cap_evt(cap_evt),
  .count_o(count_o), .cap_data_o(cap_data_o), .ovf_o(ovf_o),
  .running_o(running_o), .irq_o(irq_o)
);

// File: tb/pulse_interval_timer_test.sv
`timescale 1ns/1ps
module pulse_interval_timer_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, start = 1'b0, stop = 1'b0, swcap = 1'b0;
  logic [1:0] esel = 2'b01;
  logic filt = 1'b0, sirq = 1'b0;
  logic tick_off = 1'b0;
  int   tdiv = 1;
  int   ph = 0;
  logic tick;
  logic [W-1:0] count, cap;
  logic ovf, running, irq;

  int checks = 0, fails = 0;
  int n_irq = 0;
  logic [W-1:0] logcap [0:63];

  always #4 clk = ~clk;

  assign tick = !tick_off && ((tdiv <= 1) || (ph == 0));
  always @(posedge clk) ph <= (ph + 1 >= tdiv) ? 0 : ph + 1;

  always @(posedge clk) if (rst_n && irq) begin
    logcap[n_irq[5:0]] <= cap;
    n_irq <= n_irq + 1;
  end

  pulse_interval_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pin_i(pin), .start_i(start),
    .stop_i(stop), .sw_cap_i(swcap), .edge_sel_i(esel), .filt_en_i(filt),
    .start_irq_en_i(sirq), .count_o(count), .cap_data_o(cap), .ovf_o(ovf),
    .running_o(running), .irq_o(irq)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    start = 1'b1; step(); start = 1'b0;
  endtask
  task automatic do_stop();
    stop = 1'b1; step(); stop = 1'b0;
  endtask
  task automatic do_swcap();
    swcap = 1'b1; step(); swcap = 1'b0;
  endtask

  // Periodic pin with high 7 and low 13 cycles, four periods
  task automatic pin_run(input logic [1:0] sel, input logic f);
    int base, expn, lo;
    esel = sel; filt = f; pin = 1'b0;
    step(6);
    do_start();
    step(3);
    base = n_irq;
    for (int p = 0; p < 4; p++) begin
      pin = 1'b1; step(7);
      pin = 1'b0; step(13);
    end
    step(8);
    expn = sel[1] ? 8 : 4;
    chk(n_irq - base == expn, "R4 capture count", n_irq - base, expn);
    for (int k = base + 1; k < base + expn; k++) begin
      int e;
      if (sel[1]) e = (((k - base) % 2) == 1) ? 6 : 12;
      else        e = 19;
      chk(logcap[k[5:0]] == W'(e), "R4 interval", logcap[k[5:0]], e);
    end
    lo = 0;
    do_stop();
  endtask

  task automatic glitch_run(input logic f_at_start, input logic f_after, input int exp, input string req);
    int base;
    esel = 2'b10; pin = 1'b0; filt = f_at_start;
    step(6);
    do_start();
    filt = f_after;
    step(3);
    base = n_irq;
    pin = 1'b1; step(); pin = 1'b0;
    step(10);
    chk(n_irq - base == exp, req, n_irq - base, exp);
    do_stop();
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    chk(running == 0, "reset running", running, 0);
    chk(count == 0, "reset count", count, 0);
    chk(cap == 0, "reset cap", cap, 0);
    chk(ovf == 0 && irq == 0, "reset flags", {ovf, irq}, 0);

    // R2 start interrupt enabled
    sirq = 1'b1; do_start();
    chk(irq == 1, "R2 start irq", irq, 1);
    chk(running == 1 && count == 0, "R1 start state", count, 0);
    step();
    chk(irq == 0, "R2 irq one cycle", irq, 0);
    do_stop();
    sirq = 1'b0; do_start();
    chk(irq == 0, "R2 no start irq", irq, 0);
    do_stop();

    // R3 R5 R6 sweep over interval lengths
    for (int k = 2; k <= 300; k++) begin
      int t;
      t = k - 1;
      do_start();
      step(k - 1);
      do_swcap();
      chk(irq == 1, "R5 sw capture irq", irq, 1);
      chk(cap == W'(t % 256), "R3 capture value", cap, t % 256);
      chk(ovf == (t >= 256), "R6 overflow flag", ovf, int'(t >= 256));
      chk(count == 0, "R5 counter cleared", count, 0);
    end

    // R7 stop holds state
    step(4);
    do_stop();
    begin
      logic [W-1:0] held;
      held = count;
      step(5);
      chk(count == held, "R7 count held", count, held);
      chk(running == 0, "R7 stopped", running, 0);
      chk(ovf == 1, "R7 ovf held", ovf, 1);
      do_swcap();
      chk(irq == 0, "R7 swcap ignored irq", irq, 0);
      chk(cap == W'(299 % 256), "R7 cap held", cap, 299 % 256);
      begin
        int base;
        base = n_irq;
        esel = 2'b10;
        pin = 1'b1; step(6); pin = 1'b0; step(6);
        chk(n_irq == base, "R7 pin ignored", n_irq - base, 0);
        chk(count == held, "R7 count still held", count, held);
      end
    end

    // R1 tick gating: every third cycle
    tdiv = 3;
    do_start();
    step(30);
    for (int j = 0; j < 4; j++) begin
      do_swcap();
      chk(cap == 10, "R1 tick every third", cap, 10);
      step(30);
    end
    do_stop();
    tdiv = 1; tick_off = 1'b1;
    do_start(); step(20); do_swcap();
    chk(cap == 0, "R1 no tick no count", cap, 0);
    do_stop();
    tick_off = 1'b0;

    // R10 latency, bypass then filtered
    for (int f = 0; f < 2; f++) begin
      int base, e;
      esel = 2'b01; filt = f[0]; pin = 1'b0;
      step(6);
      do_start();
      base = n_irq;
      pin = 1'b1;
      step(8);
      e = f ? 4 : 2;
      chk(n_irq - base == 1, "R10 one capture", n_irq - base, 1);
      chk(logcap[base[5:0]] == W'(e), "R10 latency", logcap[base[5:0]], e);
      do_stop();
      pin = 1'b0;
    end

    // R4 edge polarity sweep, with and without filter
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 4; s++)
        pin_run(s[1:0], f[0]);

    // R8 glitch rejection and R9 filter sampled at start
    glitch_run(1'b1, 1'b1, 0, "R8 glitch filtered");
    glitch_run(1'b0, 1'b0, 2, "R8 glitch bypassed");
    glitch_run(1'b0, 1'b1, 2, "R9 filter change ignored");
    glitch_run(1'b1, 1'b0, 0, "R9 filter kept on");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule